// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block sits between the two bus lines of a two-wire serial bus and a byte-wide storage array. It brings SCL and SDA into the system clock domain, recognises bus Start and Stop conditions, and collects the first byte after a Start as a select code. The select code is compared with a fixed four-bit type prefix and with three strapped identity pins. A matching slave answers each byte with an acknowledge by pulling SDA low. An open-drain enable is the only way it drives SDA.

For a write, two address bytes follow the select code, high byte first. Each data byte after them becomes a single-cycle write strobe carrying an address and a byte. The data address advances only inside an aligned page. A Stop that lands in the clock slot right after an acknowledged data byte produces a commit pulse, which the storage side uses to start its internal programming cycle. For a read, the block requests bytes from storage one at a time and shifts them out. A master acknowledge asks for the next byte; a master no-acknowledge ends the read. A random read sets the address with a write header and then switches to reading after a repeated Start. A current-address read goes on from where the last access stopped.

A write-protect input, if seen high between Start and the end of the address phase, makes the block refuse every data byte of that transfer. A busy input from storage makes the block ignore Starts while a programming cycle runs.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The select byte arrives MSB first. It is acknowledged, by driving SDA low for the 9th clock, only when bits 7..4 equal 1010 and bits 3..1 equal `ce_pins[2:0]`. Bit 0 selects read (1) or write (0).
- R2: After a select byte that does not match, no later byte is acknowledged, no write strobe or commit is produced, and SDA stays released until the next Start.
- R3: In a write transfer each of the two address bytes is acknowledged, high byte first. Each data byte is then acknowledged and produces exactly one `wr_stb` carrying the current address and that byte.
- R4: After each data byte the write address increments in its low `PAGE_W` bits only (7 by default) and wraps inside the page. The upper bits do not change.
- R5: If `wr_ctrl` is high at any time from the Start until the acknowledge clock of the second address byte ends, every data byte of that transfer gets a no-acknowledge and no strobe. If `wr_ctrl` is high only during the data bytes, writing proceeds.
- R6: A random read (write header with two address bytes, repeated Start, select with read bit) returns the byte stored at that address first.
- R7: A current-address read (Start, select with read bit) returns the byte at the address one past the last byte written or read.
- R8: During a read, a master acknowledge causes the next byte to be sent, using an address incremented over the full 16 bits with wrap from FFFF to 0000. A master no-acknowledge makes the block release SDA and stay released.
- R9: While `mem_busy` is high, a Start is ignored, so even a matching select byte gets no acknowledge.
- R10: `commit_stb` pulses once for a Stop placed in the clock slot after an acknowledged data byte. A Stop after only address bytes, a Stop in the middle of a data byte, or a Stop in a transfer with no acknowledged data does not pulse it.
- R11: `sda_oe` changes only while SCL is low.
- R12: After reset `sda_oe`, `wr_stb`, `rd_req` and `commit_stb` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired-AND of all drivers) |
| sda_oe | output | 1 | Pull SDA low when 1; released when 0 |
| ce_pins | input | 3 | Strapped identity bits compared with select bits 3..1 |
| wr_ctrl | input | 1 | Write protect, active high |
| mem_busy | input | 1 | Storage programming cycle in progress |
| rd_data | input | 8 | Byte returned by storage on the cycle after `rd_req` |
| rd_req | output | 1 | Single-cycle read request |
| rd_addr | output | 16 | Address for `rd_req` |
| wr_stb | output | 1 | Single-cycle write strobe for one byte |
| wr_addr | output | 16 | Address for `wr_stb` |
| wr_data | output | 8 | Byte for `wr_stb` |
| commit_stb | output | 1 | Stop arrived in the slot after an acknowledged data byte |

## Verification
The assertions assume a well-behaved master. It changes SDA only while SCL is low, except to signal Start or Stop, and it holds each SCL phase for several system clocks, so the synchronised SCL is still low when the block updates its drive. They also assume that `mem_busy` rises and falls only while the bus is idle between a Stop and the next Start. The stimulus follows these assumptions by using eight system clocks for every quarter bit, by moving SDA a quarter bit after each SCL edge, and by toggling the busy input only after a Stop.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } phase_t;

  typedef enum logic [1:0] {
    K_SEL,
    K_AHI,
    K_ALO,
    K_DATA
  } byte_kind_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise = scl_s & ~scl_q;
    scl_fall = ~scl_s & scl_q;
    start_c  = scl_s & scl_q & sda_q & ~sda_s;
    stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int         PAGE_W = 7,
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_c,
  input  logic              stop_c,
  input  logic              sda_s,
  input  logic [2:0]        ce_pins,
  input  logic              wr_ctrl,
  input  logic              mem_busy,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              commit_stb
);
  localparam logic [PAGE_W-1:0] PG_ONE   = 1;
  localparam logic [ADDR_W-1:0] ADDR_ONE = 1;
  localparam logic [3:0]        LAST_RX  = 4'd8;
  localparam logic [3:0]        LAST_TX  = 4'd7;

  phase_t            phase;
  byte_kind_t        kind;
  logic [3:0]        bcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] addr_hi;
  logic [ADDR_W-1:0] ptr;
  logic              rw_bit;
  logic              prot;
  logic              any_acked;
  logic              m_ack;

  logic [PAGE_W-1:0] low_inc;
  logic [ADDR_W-1:0] ptr_page_next;
  logic [ADDR_W-1:0] ptr_lin_next;
  logic              sel_match;

  always_comb begin
    low_inc       = ptr[PAGE_W-1:0] + PG_ONE;
    ptr_page_next = {ptr[ADDR_W-1:PAGE_W], low_inc};
    ptr_lin_next  = ptr + ADDR_ONE;
    sel_match     = (shreg[7:4] == DEV_ID) && (shreg[3:1] == ce_pins);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= ST_IDLE;
      kind       <= K_SEL;
      bcnt       <= '0;
      shreg      <= '0;
      addr_hi    <= '0;
      ptr        <= '0;
      rw_bit     <= 1'b0;
      prot       <= 1'b0;
      any_acked  <= 1'b0;
      m_ack      <= 1'b0;
      sda_oe     <= 1'b0;
      rd_req     <= 1'b0;
      rd_addr    <= '0;
      wr_stb     <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      commit_stb <= 1'b0;
    end else begin
      wr_stb     <= 1'b0;
      rd_req     <= 1'b0;
      commit_stb <= 1'b0;
      if (stop_c) begin
        if (phase == ST_RX && kind == K_DATA && bcnt <= 4'd1 && any_acked)
          commit_stb <= 1'b1;
        phase  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_c) begin
        sda_oe    <= 1'b0;
        bcnt      <= '0;
        any_acked <= 1'b0;
        kind      <= K_SEL;
        prot      <= wr_ctrl;
        phase     <= mem_busy ? ST_IDLE : ST_RX;
      end else begin
        if (phase != ST_IDLE && kind != K_DATA && wr_ctrl) prot <= 1'b1;
        case (phase)
          ST_RX: begin
            if (scl_rise && bcnt < LAST_RX) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              bcnt  <= bcnt + 4'd1;
            end else if (scl_fall && bcnt == LAST_RX) begin
              bcnt <= '0;
              case (kind)
                K_SEL: begin
                  if (sel_match) begin
                    sda_oe <= 1'b1;
                    phase  <= ST_RXACK;
                    rw_bit <= shreg[0];
                    if (shreg[0]) begin
                      rd_req  <= 1'b1;
                      rd_addr <= ptr;
                    end
                  end else begin
                    phase <= ST_IDLE;
                  end
                end
                K_AHI: begin
                  addr_hi <= shreg;
                  sda_oe  <= 1'b1;
                  phase   <= ST_RXACK;
                end
                K_ALO: begin
                  ptr    <= {addr_hi, shreg};
                  sda_oe <= 1'b1;
                  phase  <= ST_RXACK;
                end
                default: begin
                  phase <= ST_RXACK;
                  if (!prot) begin
                    sda_oe    <= 1'b1;
                    wr_stb    <= 1'b1;
                    wr_addr   <= ptr;
                    wr_data   <= shreg;
                    ptr       <= ptr_page_next;
                    any_acked <= 1'b1;
                  end
                end
              endcase
            end
          end
          ST_RXACK: begin
            if (scl_fall) begin
              bcnt <= '0;
              if (kind == K_SEL && rw_bit) begin
                phase  <= ST_TX;
                shreg  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
              end else begin
                sda_oe <= 1'b0;
                phase  <= ST_RX;
                case (kind)
                  K_SEL:   kind <= K_AHI;
                  K_AHI:   kind <= K_ALO;
                  default: kind <= K_DATA;
                endcase
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bcnt == LAST_TX) begin
                sda_oe  <= 1'b0;
                phase   <= ST_TXACK;
                ptr     <= ptr_lin_next;
                rd_req  <= 1'b1;
                rd_addr <= ptr_lin_next;
              end else begin
                bcnt   <= bcnt + 4'd1;
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~shreg[BYTE_W-2];
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (m_ack) begin
                phase  <= ST_TX;
                bcnt   <= '0;
                shreg  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
              end else begin
                phase <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int         SYNC_STAGES = 2,
  parameter int         PAGE_W      = 7,
  parameter logic [3:0] DEV_ID      = 4'b1010
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [2:0]  ce_pins,
  input  logic        wr_ctrl,
  input  logic        mem_busy,
  input  logic [7:0]  rd_data,
  output logic        rd_req,
  output logic [15:0] rd_addr,
  output logic        wr_stb,
  output logic [15:0] wr_addr,
  output logic [7:0]  wr_data,
  output logic        commit_stb
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] syn_lines;
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_c, stop_c;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    i2cs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw_lines[g]),
      .q   (syn_lines[g])
    );
  end

  assign scl_s = syn_lines[0];
  assign sda_s = syn_lines[1];

  i2cs_cond u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c)
  );

  i2cs_engine #(.PAGE_W(PAGE_W), .DEV_ID(DEV_ID)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_c    (start_c),
    .stop_c     (stop_c),
    .sda_s      (sda_s),
    .ce_pins    (ce_pins),
    .wr_ctrl    (wr_ctrl),
    .mem_busy   (mem_busy),
    .rd_data    (rd_data),
    .sda_oe     (sda_oe),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .commit_stb (commit_stb)
  );
endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
module i2c_eeprom_slave_chk (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic sda_oe,
  input logic wr_stb,
  input logic rd_req,
  input logic commit_stb,
  input logic mem_busy
);
  // R11: the data drive moves only in the low phase of the synchronised clock
  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s);

  // R10: commit, write and read events never coincide
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_stb, rd_req, commit_stb}));

  // R3: a byte is written only together with its acknowledge
  p_wr_acked_r3: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> sda_oe);

  // R9: no drive while storage is programming
  p_busy_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    mem_busy |-> !sda_oe);

  // R12: outputs are quiet right after reset
  p_reset_clean_r12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sda_oe && !wr_stb && !commit_stb));
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .scl_s      (scl_s),
  .sda_oe     (sda_oe),
  .wr_stb     (wr_stb),
  .rd_req     (rd_req),
  .commit_stb (commit_stb),
  .mem_busy   (mem_busy)
);

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb;
  localparam int         QT    = 8;
  localparam logic [2:0] CE    = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, CE, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, CE, 1'b1};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic        scl = 1'b1;
  logic        m_sda = 1'b1;
  logic        sda_bus;
  logic        sda_oe;
  logic        wr_ctrl = 1'b0;
  logic        mem_busy = 1'b0;
  logic [7:0]  rd_data = 8'h00;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic        wr_stb;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic        commit_stb;

  assign sda_bus = m_sda & ~sda_oe;

  i2c_eeprom_slave u_dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .ce_pins(CE), .wr_ctrl(wr_ctrl), .mem_busy(mem_busy), .rd_data(rd_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit_stb(commit_stb)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int commits = 0;
  int model_ptr = 0;
  bit done = 1'b0;
  int exp_q[$];
  logic [7:0] st_mem [int];
  logic [7:0] ref_mem [int];
  logic oe_prev = 1'b0;

  task automatic check_eq(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_get(int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  // storage side model
  always @(posedge clk) begin
    if (wr_stb) st_mem[int'(wr_addr)] = wr_data;
    if (rd_req) rd_data <= st_mem.exists(int'(rd_addr)) ? st_mem[int'(rd_addr)] : 8'h00;
  end

  // per-clock comparison against the reference expectations
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_stb) begin
        if (exp_q.size() == 0) check_eq("R2 unexpected write strobe", {wr_addr, wr_data}, -1);
        else check_eq("R3/R4 write strobe addr,data", {wr_addr, wr_data}, exp_q.pop_front());
      end
      if (commit_stb) commits++;
      if (sda_oe !== oe_prev) check_eq("R11 drive change while SCL high", int'(scl), 0);
      oe_prev = sda_oe;
    end
  end

  task automatic q();
    repeat (QT) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl) begin
      m_sda = 1'b1; q(); scl = 1'b1; q();
    end
    m_sda = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; q(); scl = 1'b1; q(); m_sda = 1'b1; q(); q();
  endtask

  task automatic clk_bit(logic b);
    m_sda = b; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) clk_bit(b[i]);
    m_sda = 1'b1; q(); scl = 1'b1; q();
    ack = ~sda_bus;
    q(); scl = 1'b0; q();
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; q(); scl = 1'b1; q();
      b[i] = sda_bus;
      q(); scl = 1'b0; q();
    end
    clk_bit(~mack);
    m_sda = 1'b1;
  endtask

  // mode 0: plain, 1: protect during header, 2: protect during data only
  task automatic do_write(int addr, int n, int seed, int mode);
    logic a;
    int c0;
    logic [7:0] d;
    c0 = commits;
    if (mode == 1) wr_ctrl = 1'b1;
    bus_start();
    send_byte(DEV_W, a);           check_eq("R1 select ack (write)", a, 1);
    send_byte(addr[15:8], a);      check_eq("R3 high address ack", a, 1);
    send_byte(addr[7:0], a);       check_eq("R3 low address ack", a, 1);
    model_ptr = addr;
    if (mode == 1) wr_ctrl = 1'b0;
    if (mode == 2) wr_ctrl = 1'b1;
    for (int k = 0; k < n; k++) begin
      d = 8'((seed + k * 7) & 255);
      if (mode != 1) begin
        exp_q.push_back({model_ptr[15:0], d});
        ref_mem[model_ptr] = d;
      end
      send_byte(d, a);
      if (mode == 1) check_eq("R5 protected data nack", a, 0);
      else begin
        check_eq("R3 data ack", a, 1);
        model_ptr = (model_ptr & 32'hFF80) | ((model_ptr + 1) & 32'h7F); // R4
      end
    end
    wr_ctrl = 1'b0;
    bus_stop();
    check_eq("R10 commit after stop in slot 10", commits - c0, (mode != 1 && n > 0) ? 1 : 0);
  endtask

  task automatic do_read(int addr, int n);
    logic a;
    logic [7:0] b;
    bus_start();
    if (addr >= 0) begin
      send_byte(DEV_W, a);      check_eq("R6 header select ack", a, 1);
      send_byte(addr[15:8], a); check_eq("R6 high address ack", a, 1);
      send_byte(addr[7:0], a);  check_eq("R6 low address ack", a, 1);
      model_ptr = addr;
      bus_start();
    end
    send_byte(DEV_R, a); check_eq("R1 select ack (read)", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(b, k < n - 1);
      check_eq(addr >= 0 ? "R6/R8 read data" : "R7 current read data", b, ref_get(model_ptr));
      model_ptr = (model_ptr + 1) & 32'hFFFF;
    end
    q();
    check_eq("R8 released after master nack", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    logic a;
    int c0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check_eq("R12 sda_oe after reset", sda_oe, 0);
    check_eq("R12 wr_stb after reset", wr_stb, 0);
    check_eq("R12 rd_req after reset", rd_req, 0);
    check_eq("R12 commit after reset", commit_stb, 0);

    do_write(16'h1234, 4, 8'h11, 0);

    // R9: busy storage ignores the Start
    mem_busy = 1'b1;
    bus_start();
    send_byte(DEV_W, a); check_eq("R9 no ack while busy", a, 0);
    bus_stop();
    mem_busy = 1'b0;

    // R1/R2: wrong identity bits, then traffic that must be ignored
    c0 = commits;
    bus_start();
    send_byte({4'b1010, 3'b100, 1'b0}, a); check_eq("R1 wrong chip bits nack", a, 0);
    send_byte(8'h12, a); check_eq("R2 ignored byte 1", a, 0);
    send_byte(8'h34, a); check_eq("R2 ignored byte 2", a, 0);
    send_byte(8'h99, a); check_eq("R2 ignored byte 3", a, 0);
    bus_stop();
    check_eq("R2 no commit after mismatch", commits - c0, 0);
    bus_start();
    send_byte({4'b0010, CE, 1'b0}, a); check_eq("R1 wrong type nack", a, 0);
    bus_stop();

    do_write(16'h017E, 4, 8'h40, 0);      // R4 page wrap
    do_read(16'h1234, 3);                 // R6
    do_read(-1, 1);                       // R7
    do_read(16'h017E, 2);
    do_read(16'h0100, 2);                 // R4 wrapped bytes landed in page start
    do_write(16'h2000, 2, 8'h90, 1);      // R5 blocked
    do_write(16'h2100, 1, 8'h5A, 2);      // R5 window closed
    do_read(16'h2000, 2);
    do_read(16'h2100, 1);
    do_write(16'hFFFF, 1, 8'hC3, 0);
    do_write(16'h0000, 1, 8'h3C, 0);
    do_read(16'hFFFF, 2);                 // R8 full wrap

    // R10: Stop in the middle of a data byte
    c0 = commits;
    bus_start();
    send_byte(DEV_W, a);
    send_byte(8'h30, a);
    send_byte(8'h00, a);
    exp_q.push_back({16'h3000, 8'hA5});
    ref_mem[32'h3000] = 8'hA5;
    send_byte(8'hA5, a); check_eq("R3 data ack before partial", a, 1);
    clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1);
    bus_stop();
    check_eq("R10 no commit for mid-byte stop", commits - c0, 0);

    // R10: Stop after address bytes only
    bus_start();
    send_byte(DEV_W, a);
    send_byte(8'h30, a);
    send_byte(8'h10, a);
    bus_stop();
    check_eq("R10 no commit after address only", commits - c0, 0);
    model_ptr = 32'h3010;
    do_read(-1, 1);                       // R7 pointer from address-only header

    repeat (20) @(negedge clk);
    check_eq("R3 all expected strobes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule